// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Mode and Rewind

This block is a two-clock first-in first-out buffer for 18-bit words with a parameterized number of entries. Words enter on the write clock and leave on the read clock. Each port has its own enable. The block has two behaviours. In the standard behaviour, each read request places the next word on the output. In the fall-through behaviour, the oldest word appears on the output without a request, and a read request moves it on. The behaviour is chosen by sampling a select pin while the master reset is held. After that the pin is ignored.

A partial reset empties the buffer and clears the output register but keeps the chosen behaviour. A rewind input moves the read side back to storage location zero so that a stored sequence can be read again. The write side is not touched. Two status pins change meaning with the behaviour. In standard behaviour they report full and empty. In fall-through behaviour they report room-to-write and word-present-on-output. Both pins are active low in every behaviour.

Top module: `mode_fifo`

## Requirements
- R1: While the master reset is sampled high on both clocks, both pointers go to zero and the output data goes to all zeroes. After the reset, the buffer is empty.
- R2: The select pin is sampled only while the master reset is high. A 0 selects standard behaviour and a 1 selects fall-through. Changing the pin afterwards does not change the behaviour.
- R3: A partial reset clears both pointers and the output data, and it keeps the behaviour chosen at the last master reset.
- R4: A write is stored on a rising write-clock edge while the write enable is high and the buffer is not full. A write attempted while the buffer is full is dropped and moves no pointer.
- R5: In standard behaviour, a read request on a rising read-clock edge loads the next stored word onto the output at that edge. A read request while the buffer is empty leaves the output unchanged.
- R6: In standard behaviour, the write-status pin is low exactly when the buffer is full, and the read-status pin is low when the buffer is empty.
- R7: In fall-through behaviour, the oldest word is placed on the output without a read request, and the read-status pin is then low. A read request consumes that word and presents the next one. If no next word exists, the read-status pin goes high.
- R8: In fall-through behaviour, the write-status pin is low while space remains and high when the buffer is full.
- R9: A rewind sampled on a rising read-clock edge sets the read pointer to location zero and leaves the write pointer and the behaviour unchanged. The words from location zero onward can then be read again.
- R10: For the one read-clock cycle that follows a rewind edge, the read-status pin shows that no data is available: low in standard behaviour and high in fall-through behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| masterRst | input | 1 | Synchronous master reset, active high, sampled on both clocks |
| partialRst | input | 1 | Synchronous partial reset, active high, sampled on both clocks; keeps the behaviour |
| modeSel | input | 1 | Behaviour select sampled during master reset (0 standard, 1 fall-through) |
| wrEn | input | 1 | Write enable |
| wrData | input | DW | Write data |
| rdEn | input | 1 | Read enable |
| retransmit | input | 1 | Rewind request, sampled on rdClk |
| rdData | output | DW | Output data register |
| wrFlag | output | 1 | Full (low when full) or room-to-write (low when space remains) |
| rdFlag | output | 1 | Empty (low when empty) or word-present (low when a word is on the output) |

## Verification
A corrupted pointer shows up in the data sequence itself. A read-back that skips, repeats or invents a word shows it within one read of the fault. A pointer pair that is wrong after the buffer fills or drains shows as a stuck status pin, visible a few read cycles after the last write once the synchronizers settle. A behaviour register that is wrong shows at once after reset, because the two behaviours drive opposite idle levels on both status pins. A fault in the rewind path shows either as a missing one-cycle status pulse or as the wrong first word when the sequence is read again.

// File: rtl/mode_fifo_pkg.sv
package mode_fifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifoMode_e;

  typedef struct packed {
    logic wrDo;   // store wrData at wrAddr (write domain)
    logic rdLoad; // load output register from rdAddr (read domain)
    logic clrOut; // clear output register (read domain)
  } fifoStrobe_t;
endpackage

// File: rtl/mode_fifo_ctrl.sv
module mode_fifo_ctrl
  import mode_fifo_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic        wrClk,
  input  logic        rdClk,
  input  logic        masterRst,
  input  logic        partialRst,
  input  logic        modeSel,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic        retransmit,
  output fifoStrobe_t strb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic        wrFlag,
  output logic        rdFlag,
  output logic        fwftMode
);
  localparam int PW = AW + 1;

  logic anyRst;
  assign anyRst = masterRst | partialRst;

  // ---------------- write domain ----------------
  fifoMode_e modeW;
  logic [PW-1:0] wrBin, wrGray, wrBinNext;
  logic [PW-1:0] rdGraySyncA, rdGraySyncB;
  logic full, wrDo;

  assign wrBinNext = wrBin + PW'(1);
  assign full = (wrGray == {~rdGraySyncB[PW-1:PW-2], rdGraySyncB[PW-3:0]});
  assign wrDo = wrEn & ~full & ~anyRst;

  always_ff @(posedge wrClk) begin
    if (masterRst) modeW <= fifoMode_e'(modeSel);
    if (anyRst) begin
      wrBin       <= '0;
      wrGray      <= '0;
      rdGraySyncA <= '0;
      rdGraySyncB <= '0;
    end else begin
      rdGraySyncA <= rdGray;
      rdGraySyncB <= rdGraySyncA;
      if (wrDo) begin
        wrBin  <= wrBinNext;
        wrGray <= wrBinNext ^ (wrBinNext >> 1);
      end
    end
  end

  // ---------------- read domain ----------------
  fifoMode_e modeR;
  logic [PW-1:0] rdBin, rdGray, rdBinNext;
  logic [PW-1:0] wrGraySyncA, wrGraySyncB;
  logic outValid, rtHold, ptrEmpty, pop, rdLoad;

  assign rdBinNext = rdBin + PW'(1);
  assign ptrEmpty  = (rdGray == wrGraySyncB);
  assign pop = (modeR == MODE_FWFT) ? (~ptrEmpty & ~rtHold & (~outValid | rdEn))
                                    : (rdEn & ~ptrEmpty & ~rtHold);
  assign rdLoad = pop & ~anyRst & ~retransmit;

  always_ff @(posedge rdClk) begin
    if (masterRst) modeR <= fifoMode_e'(modeSel);
    if (anyRst) begin
      rdBin       <= '0;
      rdGray      <= '0;
      wrGraySyncA <= '0;
      wrGraySyncB <= '0;
      outValid    <= 1'b0;
      rtHold      <= 1'b0;
    end else begin
      wrGraySyncA <= wrGray;
      wrGraySyncB <= wrGraySyncA;
      if (retransmit) begin
        rdBin    <= '0;
        rdGray   <= '0;
        outValid <= 1'b0;
        rtHold   <= 1'b1;
      end else begin
        rtHold <= 1'b0;
        if (rdLoad) begin
          rdBin  <= rdBinNext;
          rdGray <= rdBinNext ^ (rdBinNext >> 1);
        end
        if (modeR == MODE_FWFT) begin
          if (rdLoad) outValid <= 1'b1;
          else if (rdEn) outValid <= 1'b0;
        end
      end
    end
  end

  // ---------------- outputs ----------------
  assign strb.wrDo   = wrDo;
  assign strb.rdLoad = rdLoad;
  assign strb.clrOut = anyRst;
  assign wrAddr   = wrBin[AW-1:0];
  assign rdAddr   = rdBin[AW-1:0];
  assign wrFlag   = (modeW == MODE_FWFT) ? full : ~full;
  assign rdFlag   = (modeR == MODE_FWFT) ? ~outValid : ~(ptrEmpty | rtHold);
  assign fwftMode = (modeR == MODE_FWFT);
endmodule

// File: rtl/mode_fifo_data.sv
module mode_fifo_data
  import mode_fifo_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 6
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  fifoStrobe_t   strb,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.wrDo) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk) begin
    if (strb.clrOut)      rdData <= '0;
    else if (strb.rdLoad) rdData <= store[rdAddr];
  end
endmodule

// File: rtl/mode_fifo.sv
module mode_fifo
  import mode_fifo_pkg::*;
#(
  parameter int DW    = 18,
  parameter int DEPTH = 64
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          masterRst,
  input  logic          partialRst,
  input  logic          modeSel,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  input  logic          rdEn,
  input  logic          retransmit,
  output logic [DW-1:0] rdData,
  output logic          wrFlag,
  output logic          rdFlag
);
  localparam int AW = $clog2(DEPTH);

  fifoStrobe_t   strb;
  logic [AW-1:0] wrAddr, rdAddr;
  logic          fwftMode;

  mode_fifo_ctrl #(.AW(AW)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .masterRst(masterRst), .partialRst(partialRst),
    .modeSel(modeSel), .wrEn(wrEn), .rdEn(rdEn), .retransmit(retransmit),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrFlag(wrFlag), .rdFlag(rdFlag), .fwftMode(fwftMode)
  );

  mode_fifo_data #(.DW(DW), .AW(AW)) u_data (
    .wrClk(wrClk), .rdClk(rdClk), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/mode_fifo_chk.sv
module mode_fifo_chk #(
  parameter int DW = 18,
  parameter int AW = 6
) (
  input logic          wrClk,
  input logic          rdClk,
  input logic          masterRst,
  input logic          partialRst,
  input logic          wrEn,
  input logic          rdEn,
  input logic          retransmit,
  input logic [DW-1:0] rdData,
  input logic          wrFlag,
  input logic          rdFlag,
  input logic [AW-1:0] wrAddr,
  input logic [AW-1:0] rdAddr,
  input logic          fwftMode
);
  logic fullSeen;
  assign fullSeen = fwftMode ? wrFlag : ~wrFlag;

  p_reset_clear_r1: assert property (@(posedge rdClk)
    masterRst |=> (rdData == '0 && rdAddr == '0));

  p_mode_hold_r2: assert property (@(posedge rdClk)
    !masterRst |=> $stable(fwftMode));

  p_partial_clear_r3: assert property (@(posedge rdClk)
    (partialRst && !masterRst) |=> (rdData == '0 && rdAddr == '0));

  p_no_overflow_r4: assert property (@(posedge wrClk) disable iff (masterRst || partialRst)
    (wrEn && fullSeen) |=> $stable(wrAddr));

  p_no_underflow_r5: assert property (@(posedge rdClk) disable iff (masterRst || partialRst)
    (!fwftMode && !rdFlag && rdEn && !retransmit) |=> $stable(rdData));

  p_rewind_r9: assert property (@(posedge rdClk) disable iff (masterRst || partialRst)
    retransmit |=> (rdAddr == '0));

  p_rewind_flag_r10: assert property (@(posedge rdClk) disable iff (masterRst || partialRst)
    retransmit |=> (rdFlag == fwftMode));
endmodule

bind mode_fifo mode_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .masterRst(masterRst), .partialRst(partialRst),
  .wrEn(wrEn), .rdEn(rdEn), .retransmit(retransmit), .rdData(rdData),
  .wrFlag(wrFlag), .rdFlag(rdFlag), .wrAddr(wrAddr), .rdAddr(rdAddr),
  .fwftMode(fwftMode)
);

// File: tb/tb_mode_fifo.sv
module tb_mode_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DW = 18;
  localparam int DEPTH = 16;
  localparam int NVEC = 6;
  // {stimulus word, expected read-back word}
  localparam logic [2*DW-1:0] VEC [NVEC] = '{
    {18'h00001, 18'h00001}, {18'h3FFFF, 18'h3FFFF}, {18'h2AAAA, 18'h2AAAA},
    {18'h15555, 18'h15555}, {18'h00000, 18'h00000}, {18'h12345, 18'h12345}
  };

  logic wrClk = 0, rdClk = 0;
  logic masterRst = 1, partialRst = 0, modeSel = 0;
  logic wrEn = 0, rdEn = 0, retransmit = 0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic wrFlag, rdFlag;
  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2)  rdClk = ~rdClk;

  mode_fifo #(.DW(DW), .DEPTH(DEPTH)) dut (
    .wrClk(wrClk), .rdClk(rdClk), .masterRst(masterRst), .partialRst(partialRst),
    .modeSel(modeSel), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .retransmit(retransmit), .rdData(rdData), .wrFlag(wrFlag), .rdFlag(rdFlag)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset(input bit master, input bit sel);
    @(negedge wrClk);
    modeSel = sel;
    if (master) masterRst = 1; else partialRst = 1;
    repeat (4) @(negedge rdClk);
    masterRst = 0; partialRst = 0;
    modeSel = ~sel; // must have no effect from here on
    repeat (2) @(negedge rdClk);
  endtask

  task automatic writeWord(input logic [DW-1:0] d);
    @(negedge wrClk); wrEn = 1; wrData = d;
    @(negedge wrClk); wrEn = 0;
  endtask

  task automatic readWord();
    @(negedge rdClk); rdEn = 1;
    @(negedge rdClk); rdEn = 0;
  endtask

  task automatic settle();
    repeat (5) @(negedge rdClk);
  endtask

  task automatic pulseRewind();
    @(negedge rdClk); retransmit = 1;
    @(negedge rdClk); retransmit = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    // R1: master reset in standard behaviour
    doReset(1, 0);
    check(rdData == '0, "R1 output cleared", rdData, '0);
    check(rdFlag == 0, "R1/R6 empty after reset", DW'(rdFlag), 0);
    check(wrFlag == 1, "R1/R6 not full after reset", DW'(wrFlag), 1);

    // R5: table-driven write then read-back
    for (int i = 0; i < NVEC; i++) writeWord(VEC[i][2*DW-1:DW]);
    settle();
    check(rdFlag == 1, "R6 not empty with data", DW'(rdFlag), 1);
    for (int i = 0; i < NVEC; i++) begin
      readWord();
      check(rdData == VEC[i][DW-1:0], "R5 read order", rdData, VEC[i][DW-1:0]);
    end
    settle();
    check(rdFlag == 0, "R6 empty after drain", DW'(rdFlag), 0);
    readWord();
    check(rdData == VEC[NVEC-1][DW-1:0], "R5 read while empty ignored", rdData, VEC[NVEC-1][DW-1:0]);

    // R4/R6: fill, overfill, drain
    for (int i = 0; i < DEPTH; i++) writeWord(DW'(18'h100 + i));
    check(wrFlag == 0, "R6 full flag", DW'(wrFlag), 0);
    writeWord(18'h3F0F0);
    check(wrFlag == 0, "R4 still full after dropped write", DW'(wrFlag), 0);
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      readWord();
      check(rdData == DW'(18'h100 + i), "R4 stored words intact", rdData, DW'(18'h100 + i));
    end
    settle();
    check(rdFlag == 0, "R4 overfill word dropped", DW'(rdFlag), 0);
    check(wrFlag == 1, "R6 not full after drain", DW'(wrFlag), 1);

    // R2: select pin toggled after reset; still standard, no fall-through
    writeWord(18'h0BEEF);
    settle();
    check(rdData == DW'(18'h10F), "R2 no fall-through after pin change", rdData, DW'(18'h10F));
    readWord();
    check(rdData == DW'(18'h0BEEF), "R5 read after idle", rdData, DW'(18'h0BEEF));

    // R3/R9/R10: partial reset then rewind in standard behaviour
    doReset(0, 1);
    check(rdData == '0, "R3 output cleared", rdData, '0);
    check(rdFlag == 0 && wrFlag == 1, "R3 standard kept", DW'({wrFlag, rdFlag}), DW'(2'b10));
    writeWord(18'h0A0A0); writeWord(18'h0B0B0); writeWord(18'h0C0C0);
    settle();
    for (int i = 0; i < 3; i++) readWord();
    check(rdData == DW'(18'h0C0C0), "R5 third word", rdData, DW'(18'h0C0C0));
    pulseRewind();
    check(rdFlag == 0, "R10 standard shows empty after rewind", DW'(rdFlag), 0);
    @(negedge rdClk);
    check(rdFlag == 1, "R10 standard data available again", DW'(rdFlag), 1);
    readWord();
    check(rdData == DW'(18'h0A0A0), "R9 reread location zero", rdData, DW'(18'h0A0A0));
    readWord(); readWord();
    settle();
    check(rdFlag == 0, "R9 write pointer kept", DW'(rdFlag), 0);

    // R7/R8: master reset into fall-through
    doReset(1, 1);
    check(rdData == '0, "R1 output cleared fall-through", rdData, '0);
    check(rdFlag == 1, "R7 no word present after reset", DW'(rdFlag), 1);
    check(wrFlag == 0, "R8 space available", DW'(wrFlag), 0);
    writeWord(18'h11111); writeWord(18'h22222);
    settle();
    check(rdData == DW'(18'h11111), "R7/R2 first word falls through", rdData, DW'(18'h11111));
    check(rdFlag == 0, "R7 word present", DW'(rdFlag), 0);
    readWord();
    check(rdData == DW'(18'h22222), "R7 read advances", rdData, DW'(18'h22222));
    readWord();
    check(rdFlag == 1, "R7 no next word", DW'(rdFlag), 1);

    // R3: partial reset keeps fall-through
    writeWord(18'h33333);
    doReset(0, 0);
    check(rdData == '0, "R3 output cleared fall-through", rdData, '0);
    check(rdFlag == 1 && wrFlag == 0, "R3 fall-through kept", DW'({wrFlag, rdFlag}), DW'(2'b01));
    writeWord(18'h04444);
    settle();
    check(rdData == DW'(18'h04444), "R3 fall-through after partial reset", rdData, DW'(18'h04444));

    // R9/R10: rewind in fall-through
    writeWord(18'h05555);
    settle();
    pulseRewind();
    check(rdFlag == 1, "R10 fall-through not ready after rewind", DW'(rdFlag), 1);
    repeat (3) @(negedge rdClk);
    check(rdData == DW'(18'h04444) && rdFlag == 0, "R9 fall-through reread location zero", rdData, DW'(18'h04444));

    // R8: fill in fall-through
    for (int i = 0; i < DEPTH + 2; i++) writeWord(DW'(i));
    check(wrFlag == 1, "R8 no space when full", DW'(wrFlag), 1);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule